// File: doc/BRIEF.md
# Trigger-Started PWM Timer with Shadowed Compares

This block is a 16-bit up-counter that drives one pulse-width-modulated output. Software programs a period value, a high-time value, a clock-division select and an enable bit through a plain write strobe. Once enabled, the timer sits idle until a rising edge on the trigger input. Then it counts prescaled ticks, wraps at the period value, and holds the output high for the first part of every period.

The counter never compares against the software-visible registers directly. It uses a shadow copy of each. The shadows are refreshed only at a counter clear, and only once software has armed the refresh by writing the high-time register. So a new period and high-time always take effect together, at a period boundary. To change only the period, software writes the period and then rewrites the high-time value. To change both, it writes the period first. A trigger edge while counting restarts the period at once, and that restart also counts as a clear.

Top module: `trig_pwm_timer`

## Requirements
- R1: While reset is held, and after it is released, `pwm_out` is 0 and the timer is disabled.
- R2: Once enabled, the timer does not count and `pwm_out` stays 0 until a rising edge on `trig_in`. The edge is detected against the previous clock's sample.
- R3: After the starting trigger edge the count runs 0, 1, …, P, where P is the shadow period. The tick after P returns it to 0, so a period lasts P+1 ticks.
- R4: `pwm_out` is 1 while the count is below the shadow high-time value H and 0 otherwise. It rises in the clock after the trigger edge or the wrap.
- R5: Writing the high-time register changes nothing in the running period. The new value applies from the next clear onward.
- R6: A period-register write alone never reaches the shadows. A high-time write arms a transfer that copies both registers at the next clear.
- R7: A tick occurs every 2^S clocks, where S is the 3-bit select in control bits [3:1]. Writes to S are ignored while the enable bit is 1.
- R8: Writing 0 to enable bit [0] forces `pwm_out` low and stops counting. Enabling again needs a fresh trigger edge.
- R9: When the enable bit goes from 0 to 1, both shadows are loaded straight from the registers, with no high-time write needed.
- R10: A trigger edge while counting restarts the count at 0 with `pwm_out` high. It applies any armed transfer.
- R11: Register addresses are: 0 = control (bit 0 enable, bits [3:1] select), 1 = period, 2 = high-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (R11) |
| wr_data | input | 16 | Write data |
| trig_in | input | 1 | External trigger, rising edge active |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check, on every cycle, the rules that depend only on local state. The count never exceeds the shadow period. Shadows hold still between clears, and a high-time write leaves the transfer armed. The select field stays frozen while enabled, a disabled timer is quiet, the enable edge loads the shadows, and a trigger forces a restart. The bench scenarios show what only a waveform over many periods can show. They cover the exact period and high-time in clocks for several settings and prescales, and the boundary at which each kind of register change lands. They also show that a lone period write has no effect, and how a mid-period retrigger reshapes the output.

// File: rtl/tpwm_pkg.sv
`timescale 1ns/1ps
package tpwm_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL   = 2'd0,
        ADR_PERIOD = 2'd1,
        ADR_WIDTH  = 2'd2
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } tmr_state_e;

    // mask with the n lowest bits set
    function automatic logic [31:0] low_ones(input logic [31:0] n);
        return (32'd1 << n) - 32'd1;
    endfunction

endpackage

// File: rtl/tpwm_regs.sv
`timescale 1ns/1ps
module tpwm_regs
    import tpwm_pkg::*;
#(
    parameter int unsigned CW = CNT_W,
    parameter int unsigned SW = SEL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]   wr_data,
    output logic            ctl_en,
    output logic [SW-1:0]   ctl_sel,
    output logic [CW-1:0]   period_reg,
    output logic [CW-1:0]   width_reg,
    output logic            width_wr
);

    reg_addr_e addr_e;
    assign addr_e   = reg_addr_e'(wr_addr);
    assign width_wr = wr_en && (addr_e == ADR_WIDTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en     <= 1'b0;
            ctl_sel    <= '0;
            period_reg <= '0;
            width_reg  <= '0;
        end else if (wr_en) begin
            case (addr_e)
                ADR_CTRL: begin
                    ctl_en <= wr_data[0];
                    if (!ctl_en)
                        ctl_sel <= wr_data[SW:1];
                end
                ADR_PERIOD: period_reg <= wr_data;
                ADR_WIDTH:  width_reg  <= wr_data;
                default: ;
            endcase
        end
    end

    // R7: division select frozen while enabled
    p_sel_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        ctl_en |=> $stable(ctl_sel));

endmodule

// File: rtl/tpwm_prescale.sv
`timescale 1ns/1ps
module tpwm_prescale
    import tpwm_pkg::*;
#(
    parameter int unsigned SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  logic [SW-1:0] sel,
    output logic          tick
);

    localparam int unsigned DIV_W = (1 << SW) - 1;

    logic [DIV_W-1:0] div_q;
    logic [31:0]      mask;

    assign mask = low_ones(32'(sel));
    assign tick = run && ((32'(div_q) & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            div_q <= '0;
        else
            div_q <= div_q + DIV_W'(1);
    end

    // R7: with a nonzero select, ticks never fall on adjacent clocks
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != '0) |=> !tick);

endmodule

// File: rtl/tpwm_core.sv
`timescale 1ns/1ps
module tpwm_core
    import tpwm_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          trig_in,
    input  logic          tick,
    input  logic [CW-1:0] period_reg,
    input  logic [CW-1:0] width_reg,
    input  logic          width_wr,
    output logic          run,
    output logic          restart,
    output logic          pwm_out
);

    tmr_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] per_buf;
    logic [CW-1:0] wid_buf;
    logic          pending;
    logic          trig_q;
    logic          trig_rise;
    logic          wrap;
    logic          clear_evt;

    assign trig_rise = trig_in && !trig_q;
    assign restart   = en && (state != ST_OFF) && trig_rise;
    assign wrap      = en && (state == ST_RUN) && tick && !restart && (cnt == per_buf);
    assign clear_evt = restart || wrap;
    assign run       = (state == ST_RUN);
    assign pwm_out   = (state == ST_RUN) && (cnt < wid_buf);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_OFF;
            cnt    <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig_in;
            if (!en) begin
                state <= ST_OFF;
                cnt   <= '0;
            end else begin
                case (state)
                    ST_OFF: begin
                        state <= ST_ARMED;
                        cnt   <= '0;
                    end
                    ST_ARMED: begin
                        if (restart) begin
                            state <= ST_RUN;
                            cnt   <= '0;
                        end
                    end
                    ST_RUN: begin
                        if (restart || wrap)
                            cnt <= '0;
                        else if (tick)
                            cnt <= cnt + CW'(1);
                    end
                    default: begin
                        state <= ST_OFF;
                        cnt   <= '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_buf <= '0;
            wid_buf <= '0;
            pending <= 1'b0;
        end else if (state == ST_OFF) begin
            pending <= 1'b0;
            if (en) begin
                per_buf <= period_reg;
                wid_buf <= width_reg;
            end
        end else begin
            if (clear_evt && pending) begin
                per_buf <= period_reg;
                wid_buf <= width_reg;
            end
            if (width_wr)
                pending <= 1'b1;
            else if (clear_evt)
                pending <= 1'b0;
        end
    end

    // R3: count stays inside the shadow period
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (cnt <= per_buf));

    // R2: idle wait holds until a trigger edge
    p_wait_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && en && !trig_rise) |=> (state == ST_ARMED && !pwm_out));

    // R5: shadows move only at a clear or at enable
    p_buf_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_OFF && !clear_evt) |=> ($stable(per_buf) && $stable(wid_buf)));

    // R6: a high-time write leaves the transfer armed
    p_arm_r6: assert property (@(posedge clk) disable iff (rst)
        (width_wr && state != ST_OFF) |=> pending);

    // R8: disabled timer is quiet
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == ST_OFF && cnt == '0 && !pwm_out));

    // R9: enable edge loads both shadows from the registers
    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && en) |=>
            (per_buf == $past(period_reg) && wid_buf == $past(width_reg)));

    // R10: trigger restarts the count
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (state == ST_RUN && cnt == '0));

endmodule

// File: rtl/trig_pwm_timer.sv
`timescale 1ns/1ps
module trig_pwm_timer
    import tpwm_pkg::*;
#(
    parameter int unsigned CW = CNT_W,
    parameter int unsigned SW = SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic              trig_in,
    output logic              pwm_out
);

    logic          ctl_en;
    logic [SW-1:0] ctl_sel;
    logic [CW-1:0] period_reg;
    logic [CW-1:0] width_reg;
    logic          width_wr;
    logic          run;
    logic          restart;
    logic          tick;

    tpwm_regs #(.CW(CW), .SW(SW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ctl_en     (ctl_en),
        .ctl_sel    (ctl_sel),
        .period_reg (period_reg),
        .width_reg  (width_reg),
        .width_wr   (width_wr)
    );

    tpwm_prescale #(.SW(SW)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .sel     (ctl_sel),
        .tick    (tick)
    );

    tpwm_core #(.CW(CW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .en         (ctl_en),
        .trig_in    (trig_in),
        .tick       (tick),
        .period_reg (period_reg),
        .width_reg  (width_reg),
        .width_wr   (width_wr),
        .run        (run),
        .restart    (restart),
        .pwm_out    (pwm_out)
    );

endmodule

// File: tb/sim_trig_pwm_timer.sv
`timescale 1ns/1ps
module sim_trig_pwm_timer;

    localparam int CW = 16;
    localparam logic [1:0] A_CTRL = 2'd0;   // R11 address map
    localparam logic [1:0] A_PER  = 2'd1;
    localparam logic [1:0] A_WID  = 2'd2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          trig = 1'b0;
    logic          pwm;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cur = 0;
    bit    q_val[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    trig_pwm_timer u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .trig_in (trig),
        .pwm_out (pwm)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: pwm_out=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // monitor: one expected output bit per clock, sampled away from the edge
    always @(negedge clk) begin
        if (q_val.size() > 0) begin
            bit    e;
            string t;
            e = q_val.pop_front();
            t = q_tag.pop_front();
            check(pwm, e, t);
        end
    end

    // expected waveform from R3/R4/R7: period (P+1)*2^S clocks, high for H*2^S
    task automatic push_pat(input int per, input int wid, input int sel,
                            input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int ph;
            ph = (i % ((per + 1) << sel)) >> sel;
            q_val.push_back(ph < wid);
            q_tag.push_back(tag);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // write landing on clock edge k counted from the starting trigger edge
    task automatic wr_at(input int k, input logic [1:0] a, input logic [CW-1:0] d);
        repeat (k - 1 - cur) @(posedge clk);
        do_write(a, d);
        cur = k;
    endtask

    task automatic trig_at(input int k);
        repeat (k - 1 - cur) @(posedge clk);
        @(negedge clk); trig = 1'b1;
        @(posedge clk);
        @(negedge clk); trig = 1'b0;
        cur = k;
    endtask

    task automatic trig_rise_now();
        @(negedge clk); trig = 1'b1;
        @(posedge clk);
    endtask

    task automatic drain();
        while (q_val.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) begin @(negedge clk); check(pwm, 1'b0, "R1"); end
        rst = 1'b0;
        repeat (3) begin @(negedge clk); check(pwm, 1'b0, "R1"); end

        // R2: enabled but waiting for trigger
        do_write(A_PER, 16'd9);
        do_write(A_WID, 16'd3);
        do_write(A_CTRL, 16'h0001);
        repeat (8) begin @(negedge clk); check(pwm, 1'b0, "R2"); end

        // segment 1, prescale 1
        trig_rise_now();
        push_pat(9, 3, 0, 10, "R3");   // entries 0..9, first period
        push_pat(9, 6, 0, 20, "R5");   // 10..29, high-time change lands at clear
        push_pat(9, 6, 0, 10, "R6");   // 30..39, lone period write had no effect
        push_pat(5, 2, 0, 3,  "R6");   // 40..42, both applied after armed clear
        push_pat(5, 4, 0, 12, "R10");  // 43..54, retrigger mid-period
        @(negedge clk); trig = 1'b0;
        cur = 0;
        wr_at(4,  A_WID, 16'd6);
        wr_at(14, A_PER, 16'd5);
        wr_at(34, A_WID, 16'd2);
        wr_at(41, A_WID, 16'd4);
        trig_at(43);
        drain();

        // R8: disable quiets the output
        do_write(A_CTRL, 16'h0000);
        repeat (2) @(negedge clk);
        repeat (6) begin @(negedge clk); check(pwm, 1'b0, "R8"); end

        // R9: period written last, no high-time write afterwards
        do_write(A_WID, 16'd2);
        do_write(A_PER, 16'd7);
        do_write(A_CTRL, 16'h0003);    // enable, select 1
        repeat (6) begin @(negedge clk); check(pwm, 1'b0, "R8"); end

        // segment 2, divide by 2; select change while enabled ignored
        trig_rise_now();
        push_pat(7, 2, 1, 16, "R9");
        push_pat(7, 2, 1, 32, "R7");
        @(negedge clk); trig = 1'b0;
        cur = 0;
        wr_at(5, A_CTRL, 16'h0001);
        drain();

        summary();
        $finish;
    end

endmodule